// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block sequences a microcontroller core through seven power modes: high-speed and medium-speed (the CPU runs on the main clock), sleep (CPU halted, main clock running), software standby (everything stopped), watch (only the subclock and its timer run), subactive (the CPU runs on the subclock) and subsleep (CPU halted, subclock running). Software programs four flag bits in an 8-bit control register. When the core executes its sleep instruction, it raises a one-cycle strobe. The block then picks the next mode from the current mode, the flags and two side-band request bits. One request bit asks for a stop-class mode rather than sleep. The other asks to keep the timer alive, which selects watch instead of software standby.

Wake-up is driven by an enabled-interrupt input and an oscillator-settled handshake input. From the current mode the block derives the enables for the main clock, the subclock and the CPU clock. It also generates a noise-filter sampling tick whose rate is picked by one of the register flags.

Top module: `lpm_ctrl`

## Requirements
- R1: The control register resets to 0x00. Its flags are direct-transfer at bit 7, low-speed at bit 6, noise-filter rate at bit 5 and subclock enable at bit 4; all four are read/write. Bits 3..0 read as 0 whatever is written to them.
- R2: With direct-transfer clear and the stop request low, a sleep strobe in high-speed (`mode_o`=0) or medium-speed (1) mode enters sleep (2). An interrupt in sleep returns to the mode that issued the strobe.
- R3: With direct-transfer clear and the stop request high, high-speed mode enters watch (4) when the keep-timer request is high and software standby (3) when it is low. From medium-speed mode it always enters software standby.
- R4: With direct-transfer and low-speed both set, a sleep strobe in high-speed mode enters subactive (5) if the subclock enable is set. If the subclock enable is clear, or the strobe comes from medium-speed mode, the block falls back to sleep (stop request low) or software standby (stop request high).
- R5: With direct-transfer set and low-speed clear, a sleep strobe in high-speed or medium-speed mode enters software standby if the stop request is high and sleep otherwise. The keep-timer request is ignored.
- R6: In subactive mode, a sleep strobe with direct-transfer clear or low-speed set enters watch (stop request high) or subsleep (6, stop request low). An interrupt in subsleep returns to subactive.
- R7: In subactive mode, a sleep strobe with direct-transfer set and low-speed clear moves straight to high-speed mode.
- R8: In software standby, an interrupt arms a pending wake that raises the main clock enable. Only a later oscillator-settled input then moves the block to high-speed. The oscillator input alone has no effect.
- R9: In watch, an interrupt moves the block to subactive at once when low-speed is set. When low-speed is clear, the block leaves watch for high-speed through the same pending-wake handshake as R8.
- R10: The CPU clock enable is high only in modes 0, 1 and 5. The main clock enable is high in modes 0, 1 and 2 and while a wake is pending. The subclock enable equals the subclock flag, except in software standby, where it is low.
- R11: While the CPU runs on the main clock, the medium-speed request selects mode 1 (high) or mode 0 (low). It is ignored in subactive mode. A sleep strobe has no effect in any halted or stopped mode.
- R12: The noise-filter sampling tick pulses once every 32 clock cycles when the rate flag is clear and once every 4 cycles when it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| sleep_i | input | 1 | Sleep instruction strobe |
| stop_req_i | input | 1 | Request a stop-class mode instead of sleep |
| keep_tmr_i | input | 1 | Keep timer running: watch instead of software standby |
| med_req_i | input | 1 | Request medium-speed while running on the main clock |
| irq_i | input | 1 | Enabled interrupt (wake-up event) |
| osc_ready_i | input | 1 | Main oscillator settled handshake |
| mode_o | output | 3 | Current mode code |
| main_clk_en_o | output | 1 | Main clock enable |
| sub_clk_en_o | output | 1 | Subclock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| nf_tick_o | output | 1 | Noise-filter sampling tick |

## Verification
The sleep strobe is applied with every combination of direct-transfer and low-speed, from high-speed, medium-speed and subactive, with both the stop and the keep-timer requests toggled. This separates the three decision paths and shows that medium-speed demotes watch and subactive requests. Each stop-class mode is left twice: once by the oscillator input alone and once by interrupt followed by oscillator. This shows that the pending-wake stage is required and that low-speed chooses the exit target of watch. Clock enables are compared on every cycle, so a mode that is correct but has wrong gating is also caught.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_HIGH   = 3'd0,
    M_MED    = 3'd1,
    M_SLEEP  = 3'd2,
    M_SSBY   = 3'd3,
    M_WATCH  = 3'd4,
    M_SUBACT = 3'd5,
    M_SUBSLP = 3'd6
  } lpm_mode_e;

  typedef struct packed {
    logic dton;
    logic lson;
    logic nesel;
    logic excle;
  } lpm_cfg_t;

  localparam int unsigned CFG_W = 4;
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg import lpm_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output lpm_cfg_t      cfg_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned RSVD_W = DW - CFG_W;

  lpm_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= lpm_cfg_t'(wdata_i[DW-1 -: CFG_W]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q, {RSVD_W{1'b0}}};
endmodule

// File: rtl/lpm_next_mode.sv
module lpm_next_mode import lpm_pkg::*; (
  input  lpm_mode_e mode_i,
  input  logic      pend_i,
  input  logic      ret_med_i,
  input  logic      dton_i,
  input  logic      lson_i,
  input  logic      excle_i,
  input  logic      sleep_i,
  input  logic      stop_req_i,
  input  logic      keep_tmr_i,
  input  logic      med_req_i,
  input  logic      irq_i,
  input  logic      osc_ready_i,
  output lpm_mode_e mode_o,
  output logic      pend_o,
  output logic      ret_med_o
);
  lpm_mode_e fallback;

  always_comb begin
    fallback  = stop_req_i ? M_SSBY : M_SLEEP;
    mode_o    = mode_i;
    pend_o    = pend_i;
    ret_med_o = ret_med_i;
    unique case (mode_i)
      M_HIGH, M_MED: begin
        if (sleep_i) begin
          ret_med_o = (mode_i == M_MED);
          if (!dton_i) begin
            if (!stop_req_i)                           mode_o = M_SLEEP;
            else if (keep_tmr_i && mode_i == M_HIGH)   mode_o = M_WATCH;
            else                                       mode_o = M_SSBY;
          end else if (lson_i && excle_i && mode_i == M_HIGH) begin
            mode_o = M_SUBACT;
          end else begin
            mode_o = fallback;
          end
        end else begin
          mode_o = med_req_i ? M_MED : M_HIGH;
        end
      end
      M_SLEEP: if (irq_i) mode_o = ret_med_i ? M_MED : M_HIGH;
      M_SSBY: begin
        if (pend_i) begin
          if (osc_ready_i) begin
            mode_o = M_HIGH;
            pend_o = 1'b0;
          end
        end else if (irq_i) begin
          pend_o = 1'b1;
        end
      end
      M_WATCH: begin
        if (pend_i) begin
          if (osc_ready_i) begin
            mode_o = M_HIGH;
            pend_o = 1'b0;
          end
        end else if (irq_i) begin
          if (lson_i) mode_o = M_SUBACT;
          else        pend_o = 1'b1;
        end
      end
      M_SUBACT: begin
        if (sleep_i) begin
          if (dton_i && !lson_i) mode_o = M_HIGH;
          else                   mode_o = stop_req_i ? M_WATCH : M_SUBSLP;
        end
      end
      M_SUBSLP: if (irq_i) mode_o = M_SUBACT;
      default: begin
        mode_o = M_HIGH;
        pend_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lpm_nf_div.sv
module lpm_nf_div #(
  parameter int unsigned DIV_SLOW = 32,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? LIM_FAST : LIM_SLOW;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl import lpm_pkg::*; #(
  parameter int unsigned DW       = 8,
  parameter int unsigned DIV_SLOW = 32,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          sleep_i,
  input  logic          stop_req_i,
  input  logic          keep_tmr_i,
  input  logic          med_req_i,
  input  logic          irq_i,
  input  logic          osc_ready_i,
  output logic [2:0]    mode_o,
  output logic          main_clk_en_o,
  output logic          sub_clk_en_o,
  output logic          cpu_clk_en_o,
  output logic          nf_tick_o
);
  lpm_cfg_t  cfg;
  lpm_mode_e mode_q, mode_d;
  logic      pend_q, pend_d;
  logic      ret_med_q, ret_med_d;

  lpm_cfg_reg #(.DW(DW)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  lpm_next_mode u_nxt (
    .mode_i      (mode_q),
    .pend_i      (pend_q),
    .ret_med_i   (ret_med_q),
    .dton_i      (cfg.dton),
    .lson_i      (cfg.lson),
    .excle_i     (cfg.excle),
    .sleep_i     (sleep_i),
    .stop_req_i  (stop_req_i),
    .keep_tmr_i  (keep_tmr_i),
    .med_req_i   (med_req_i),
    .irq_i       (irq_i),
    .osc_ready_i (osc_ready_i),
    .mode_o      (mode_d),
    .pend_o      (pend_d),
    .ret_med_o   (ret_med_d)
  );

  lpm_nf_div #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_nf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fast_i (cfg.nesel),
    .tick_o (nf_tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_HIGH;
      pend_q    <= 1'b0;
      ret_med_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      pend_q    <= pend_d;
      ret_med_q <= ret_med_d;
    end
  end

  always_comb begin
    cpu_clk_en_o  = 1'b0;
    main_clk_en_o = pend_q;
    unique case (mode_q)
      M_HIGH, M_MED: begin
        cpu_clk_en_o  = 1'b1;
        main_clk_en_o = 1'b1;
      end
      M_SLEEP:  main_clk_en_o = 1'b1;
      M_SUBACT: cpu_clk_en_o  = 1'b1;
      default: ;
    endcase
  end

  assign sub_clk_en_o = cfg.excle && (mode_q != M_SSBY);
  assign mode_o       = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk import lpm_pkg::*; (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       irq_i,
  input logic       osc_ready_i,
  input logic       main_clk_en_i,
  input logic       dton_i,
  input logic       lson_i,
  input logic       excle_i
);
  AST_WATCH_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_WATCH && $past(mode_i) != M_WATCH) |->
      ($past(mode_i) == M_HIGH || $past(mode_i) == M_SUBACT)); // R3

  AST_SUBACT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_SUBACT && $past(mode_i) == M_HIGH) |->
      ($past(dton_i) && $past(lson_i) && $past(excle_i))); // R4

  AST_SSBY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == M_SSBY && mode_i != M_SSBY) |->
      (mode_i == M_HIGH && $past(osc_ready_i) && $past(main_clk_en_i))); // R8

  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == M_SLEEP && mode_i != M_SLEEP) |->
      ($past(irq_i) && (mode_i == M_HIGH || mode_i == M_MED))); // R2

  AST_SUBSLP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_SUBSLP && !irq_i) |=> (mode_i == M_SUBSLP)); // R6
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_o),
  .irq_i         (irq_i),
  .osc_ready_i   (osc_ready_i),
  .main_clk_en_i (main_clk_en_o),
  .dton_i        (reg_rdata_o[7]),
  .lson_i        (reg_rdata_o[6]),
  .excle_i       (reg_rdata_o[4])
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       sleep_i = 1'b0, stop_req_i = 1'b0, keep_tmr_i = 1'b0;
  logic       med_req_i = 1'b0, irq_i = 1'b0, osc_ready_i = 1'b0;
  logic [2:0] mode_o;
  logic       main_clk_en_o, sub_clk_en_o, cpu_clk_en_o, nf_tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_excle = 1'b0;

  typedef struct {
    logic [2:0] mode;
    logic       main;
    logic       sub;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  lpm_ctrl dut (.*);

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] m, input logic mn, input string tag);
    item_t it;
    it.mode = m;
    it.main = mn;
    it.sub  = exp_excle && (m != 3'd3);
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic step(input logic slp, stp, kp, md, irq, osc,
                      input logic [2:0] em, input logic emain, input string tag);
    @(negedge clk_i);
    reg_we_i = 1'b0; sleep_i = slp; stop_req_i = stp; keep_tmr_i = kp;
    med_req_i = md; irq_i = irq; osc_ready_i = osc;
    push(em, emain, tag);
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] em, input logic emain);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d; sleep_i = 1'b0; stop_req_i = 1'b0;
    keep_tmr_i = 1'b0; irq_i = 1'b0; osc_ready_i = 1'b0;
    exp_excle = d[4];
    push(em, emain, "R1 write");
    @(posedge clk_i); #2;
    check(reg_rdata_o == {d[7:4], 4'h0}, "R1 readback", reg_rdata_o, {d[7:4], 4'h0});
  endtask

  // monitor: pop one expectation per cycle after the edge
  initial begin
    forever begin
      @(posedge clk_i); #2;
      if (sb_q.size() > 0) begin
        item_t it;
        logic ecpu;
        it = sb_q.pop_front();
        ecpu = (it.mode == 3'd0 || it.mode == 3'd1 || it.mode == 3'd5);
        check(mode_o == it.mode, {it.tag, " mode"}, mode_o, it.mode);
        if (main_clk_en_o !== it.main || cpu_clk_en_o !== ecpu || sub_clk_en_o !== it.sub) begin
          checks++; errors++;
          $display("FAIL R10 %s main/cpu/sub actual=%b%b%b expected=%b%b%b", it.tag,
                   main_clk_en_o, cpu_clk_en_o, sub_clk_en_o, it.main, ecpu, it.sub);
        end else checks++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check(mode_o == 3'd0 && reg_rdata_o == 8'h00, "R1 reset state", {reg_rdata_o, 5'd0, mode_o}, 0);
    check(cpu_clk_en_o && main_clk_en_o && !sub_clk_en_o, "R10 reset enables",
          {cpu_clk_en_o, main_clk_en_o, sub_clk_en_o}, 3'b110);

    // cfg = 0
    step(1,0,0,0,0,0, 3'd2, 1, "R2 high->sleep");
    step(1,0,0,0,0,0, 3'd2, 1, "R11 strobe ignored in sleep");
    step(0,0,0,0,1,0, 3'd0, 1, "R2 wake to high");
    step(0,0,0,1,0,0, 3'd1, 1, "R11 medium request");
    step(1,0,0,1,0,0, 3'd2, 1, "R2 med->sleep");
    step(0,0,0,1,1,0, 3'd1, 1, "R2 wake to med");
    step(1,1,1,1,0,0, 3'd3, 0, "R3 med watch demoted");
    step(0,0,0,0,0,1, 3'd3, 0, "R8 osc alone ignored");
    step(0,0,0,0,1,0, 3'd3, 1, "R8 pending wake");
    step(0,0,0,0,0,1, 3'd0, 1, "R8 exit to high");
    step(1,1,1,0,0,0, 3'd4, 0, "R3 high->watch");
    step(1,0,0,0,0,0, 3'd4, 0, "R11 strobe ignored in watch");
    step(0,0,0,0,1,0, 3'd4, 1, "R9 watch pending");
    step(0,0,0,0,0,1, 3'd0, 1, "R9 watch exit high");
    step(1,1,0,0,0,0, 3'd3, 0, "R3 high->standby");
    step(0,0,0,0,1,0, 3'd3, 1, "R8 pending");
    step(0,0,0,0,0,1, 3'd0, 1, "R8 exit");

    // dton+lson, subclock off
    wr(8'hCF, 3'd0, 1);
    step(1,0,0,0,0,0, 3'd2, 1, "R4 no subclock -> sleep");
    step(0,0,0,0,1,0, 3'd0, 1, "R2 wake");
    step(1,1,0,0,0,0, 3'd3, 0, "R4 no subclock -> standby");
    step(0,0,0,0,1,0, 3'd3, 1, "R8 pending");
    step(0,0,0,0,0,1, 3'd0, 1, "R8 exit");

    // dton+lson+excle
    wr(8'hD0, 3'd0, 1);
    step(0,0,0,1,0,0, 3'd1, 1, "R11 to med");
    step(1,0,0,1,0,0, 3'd2, 1, "R4 med fallback sleep");
    step(0,0,0,1,1,0, 3'd1, 1, "R2 back to med");
    step(0,0,0,0,0,0, 3'd0, 1, "R11 back to high");
    step(1,0,0,0,0,0, 3'd5, 0, "R4 high->subactive");
    step(0,0,0,1,0,0, 3'd5, 0, "R11 med ignored in subactive");
    step(1,0,0,0,0,0, 3'd6, 0, "R6 subactive->subsleep");
    step(0,0,0,0,0,0, 3'd6, 0, "R6 subsleep holds");
    step(0,0,0,0,1,0, 3'd5, 0, "R6 subsleep wake");
    step(1,1,0,0,0,0, 3'd4, 0, "R6 subactive->watch");
    step(0,0,0,0,1,0, 3'd5, 0, "R9 watch->subactive");

    // dton, lson clear
    wr(8'h90, 3'd5, 0);
    step(1,0,0,0,0,0, 3'd0, 1, "R7 subactive->high");
    step(1,1,1,0,0,0, 3'd3, 0, "R5 keep ignored -> standby");
    step(0,0,0,0,1,0, 3'd3, 1, "R8 pending");
    step(0,0,0,0,0,1, 3'd0, 1, "R8 exit");
    step(1,0,1,0,0,0, 3'd2, 1, "R5 -> sleep");
    step(0,0,0,0,1,0, 3'd0, 1, "R2 wake");

    // lson only
    wr(8'h50, 3'd0, 1);
    step(1,1,1,0,0,0, 3'd4, 0, "R3 high->watch lson");
    step(0,0,0,0,1,0, 3'd5, 0, "R9 watch->subactive");
    step(1,0,0,0,0,0, 3'd6, 0, "R6 dton clear subsleep");
    step(0,0,0,0,1,0, 3'd5, 0, "R6 wake");
    wr(8'h90, 3'd5, 0);
    step(1,0,0,0,0,0, 3'd0, 1, "R7 back to high");
    step(0,0,0,0,0,0, 3'd0, 1, "R11 idle");
    @(negedge clk_i);
    sleep_i = 1'b0; irq_i = 1'b0; osc_ready_i = 1'b0;
    repeat (2) @(posedge clk_i);
    check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);

    // noise filter tick rate
    wr(8'h00, 3'd0, 1);
    do begin @(posedge clk_i); #2; end while (!nf_tick_o);
    n = 0;
    do begin @(posedge clk_i); #2; n++; end while (!nf_tick_o);
    check(n == 32, "R12 slow tick period", n, 32);
    wr(8'h20, 3'd0, 1);
    do begin @(posedge clk_i); #2; end while (!nf_tick_o);
    n = 0;
    do begin @(posedge clk_i); #2; n++; end while (!nf_tick_o);
    check(n == 4, "R12 fast tick period", n, 4);

    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule